// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block steps the instruction address of a small microcontroller core. It holds a 13-bit counter that covers an 8K-word program space, and an eight-level stack of full 13-bit return addresses. Each cycle the instruction decoder raises at most one of a handful of strobes: advance, jump, subroutine call, and three kinds of return. The interrupt controller raises a separate accept strobe. The block puts the next counter value in place by the following clock edge.

Only the low part of the program space is built. A parameter gives the number of implemented words, 1024 or 2048. The fetch address sent to the program memory is the counter with its upper bits cleared, so any address above the implemented size aliases onto real memory. The logical counter value is also brought out so that the core can read it.

The stack is circular and has no overflow or underflow indication. After eight pushes, the next push overwrites the oldest entry. A pop on an empty stack yields whatever entry the wrapped pointer selects.

Top module: `prog_seq_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the counter and the fetch address are 0000h. Every stack entry reads as 0000h.
- R2: With only the advance strobe raised, the counter becomes its previous value plus one one cycle later, and 1FFFh advances to 0000h.
- R3: A jump strobe loads the 13-bit target input into the counter at the next edge.
- R4: A call strobe loads the target into the counter and pushes the old counter value plus one. A later return restores that value.
- R5: The plain return, the return-from-interrupt and the return-with-literal strobes each pop the top stack entry into the counter, in last-in first-out order.
- R6: An accepted interrupt loads 0004h and pushes the current counter value, which is the address that would have run next. A return-from-interrupt later resumes there.
- R7: Reset takes precedence over interrupt accept. Interrupt accept takes precedence over every other strobe in the same cycle, and those strobes then neither move the counter nor touch the stack.
- R8: The fetch address equals the counter modulo the implemented size, so it is always below that size (the low 10 bits for the default of 1024 words).
- R9: The stack holds eight entries circularly. After nine pushes p1..p9, nine pops return p9, p8, ..., p2 and then p9 again. A pop right after reset returns 0000h.
- R10: With no strobe raised, the counter holds its value.
- R11: Among simultaneous decoder strobes, call beats jump, jump beats any return, and any return beats advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| irqTake | input | 1 | Interrupt accepted this cycle |
| incEn | input | 1 | Advance counter by one |
| jumpEn | input | 1 | Load target address |
| callEn | input | 1 | Push return address and load target |
| retEn | input | 1 | Plain return, pop |
| retfieEn | input | 1 | Return from interrupt, pop |
| retlwEn | input | 1 | Return carrying a literal, pop |
| jumpAddr | input | 13 | Target address for jump and call |
| fetchAddr | output | 13 | Physical program memory address |
| pcValue | output | 13 | Logical counter value |

## Verification
A wrong stack pointer or a corrupted entry does not show on the ports when it happens. It only shows when a return loads a wrong counter value, which can be several calls later, so the bench nests calls, interrupts and wrapped pushes before it unwinds them. A wrong counter update or priority decision shows one cycle after the strobe on both outputs. A wrong mask shows as a fetch address that differs from the counter's low bits as soon as the counter crosses the implemented size.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_INC,
    SRC_JUMP,
    SRC_IRQ,
    SRC_POP
  } pcSrc_e;

  typedef struct packed {
    pcSrc_e pcSrc;
    logic   doPush;
    logic   doPop;
    logic   pushNext;   // push counter+1 instead of counter
  } seqCtrl_t;
endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic     irqTake,
  input  logic     incEn,
  input  logic     jumpEn,
  input  logic     callEn,
  input  logic     retEn,
  input  logic     retfieEn,
  input  logic     retlwEn,
  output seqCtrl_t ctl
);
  logic anyRet;
  assign anyRet = retEn | retfieEn | retlwEn;

  always_comb begin
    ctl = '{pcSrc: SRC_HOLD, doPush: 1'b0, doPop: 1'b0, pushNext: 1'b0};
    if (irqTake) begin
      ctl.pcSrc  = SRC_IRQ;
      ctl.doPush = 1'b1;
    end else if (callEn) begin
      ctl.pcSrc    = SRC_JUMP;
      ctl.doPush   = 1'b1;
      ctl.pushNext = 1'b1;
    end else if (jumpEn) begin
      ctl.pcSrc = SRC_JUMP;
    end else if (anyRet) begin
      ctl.pcSrc = SRC_POP;
      ctl.doPop = 1'b1;
    end else if (incEn) begin
      ctl.pcSrc = SRC_INC;
    end
  end
endmodule

// File: rtl/pcs_stack.sv
module pcs_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             doPush,
  input  logic             doPop,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] topData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrDec;
  logic [WIDTH-1:0] entry [DEPTH];

  assign ptrDec  = ptr - PTR_W'(1);
  assign topData = entry[ptrDec];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (doPush) begin
      ptr <= ptr + PTR_W'(1);
    end else if (doPop) begin
      ptr <= ptrDec;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entry[i] <= '0;
      end else if (doPush && (ptr == PTR_W'(i))) begin
        entry[i] <= pushData;
      end
    end
  end
endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int PC_W       = 13,
  parameter int IMPL_WORDS = 1024,
  parameter int RESET_VEC  = 0,
  parameter int IRQ_VEC    = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqCtrl_t        ctl,
  input  logic [PC_W-1:0] jumpAddr,
  input  logic [PC_W-1:0] topData,
  output logic [PC_W-1:0] pushData,
  output logic [PC_W-1:0] pcValue,
  output logic [PC_W-1:0] fetchAddr
);
  localparam int IMPL_BITS = $clog2(IMPL_WORDS);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] pcInc;
  logic [PC_W-1:0] pcNext;

  assign pcInc    = pc + PC_W'(1);
  assign pushData = ctl.pushNext ? pcInc : pc;

  always_comb begin
    unique case (ctl.pcSrc)
      SRC_INC:  pcNext = pcInc;
      SRC_JUMP: pcNext = jumpAddr;
      SRC_IRQ:  pcNext = PC_W'(IRQ_VEC);
      SRC_POP:  pcNext = topData;
      default:  pcNext = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= PC_W'(RESET_VEC);
    else       pc <= pcNext;
  end

  assign pcValue = pc;

  if (IMPL_BITS >= PC_W) begin : g_full
    assign fetchAddr = pc;
  end else begin : g_alias
    assign fetchAddr = {{(PC_W-IMPL_BITS){1'b0}}, pc[IMPL_BITS-1:0]};
  end
endmodule

// File: rtl/prog_seq_unit.sv
module prog_seq_unit
  import pcs_pkg::*;
#(
  parameter int PC_W        = 13,
  parameter int STACK_DEPTH = 8,
  parameter int IMPL_WORDS  = 1024,
  parameter int RESET_VEC   = 0,
  parameter int IRQ_VEC     = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            irqTake,
  input  logic            incEn,
  input  logic            jumpEn,
  input  logic            callEn,
  input  logic            retEn,
  input  logic            retfieEn,
  input  logic            retlwEn,
  input  logic [PC_W-1:0] jumpAddr,
  output logic [PC_W-1:0] fetchAddr,
  output logic [PC_W-1:0] pcValue
);
  seqCtrl_t        ctl;
  logic [PC_W-1:0] topData;
  logic [PC_W-1:0] pushData;

  pcs_ctrl u_ctrl (
    .irqTake (irqTake),
    .incEn   (incEn),
    .jumpEn  (jumpEn),
    .callEn  (callEn),
    .retEn   (retEn),
    .retfieEn(retfieEn),
    .retlwEn (retlwEn),
    .ctl     (ctl)
  );

  pcs_datapath #(
    .PC_W      (PC_W),
    .IMPL_WORDS(IMPL_WORDS),
    .RESET_VEC (RESET_VEC),
    .IRQ_VEC   (IRQ_VEC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .jumpAddr (jumpAddr),
    .topData  (topData),
    .pushData (pushData),
    .pcValue  (pcValue),
    .fetchAddr(fetchAddr)
  );

  pcs_stack #(
    .DEPTH(STACK_DEPTH),
    .WIDTH(PC_W)
  ) u_stack (
    .clk     (clk),
    .rstN    (rstN),
    .doPush  (ctl.doPush),
    .doPop   (ctl.doPop),
    .pushData(pushData),
    .topData (topData)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int PC_W       = 13,
  parameter int IMPL_WORDS = 1024,
  parameter int RESET_VEC  = 0,
  parameter int IRQ_VEC    = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            irqTake,
  input logic            incEn,
  input logic            jumpEn,
  input logic            callEn,
  input logic            retEn,
  input logic            retfieEn,
  input logic            retlwEn,
  input logic [PC_W-1:0] jumpAddr,
  input logic [PC_W-1:0] fetchAddr,
  input logic [PC_W-1:0] pcValue
);
  logic anyRet;
  logic noStrobe;
  assign anyRet   = retEn | retfieEn | retlwEn;
  assign noStrobe = !(irqTake | incEn | jumpEn | callEn | anyRet);

  // R1: first cycle out of reset shows the reset vector
  a_r1_reset_vec: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> pcValue == PC_W'(RESET_VEC));

  // R2: lone advance adds one
  a_r2_advance: assert property (@(posedge clk) disable iff (!rstN)
    (incEn && !irqTake && !callEn && !jumpEn && !anyRet)
      |=> pcValue == $past(pcValue) + PC_W'(1));

  // R3 / R11: jump without call or interrupt takes the target
  a_r3_jump_target: assert property (@(posedge clk) disable iff (!rstN)
    (jumpEn && !callEn && !irqTake) |=> pcValue == $past(jumpAddr));

  // R4: call takes the target
  a_r4_call_target: assert property (@(posedge clk) disable iff (!rstN)
    (callEn && !irqTake) |=> pcValue == $past(jumpAddr));

  // R6 / R7: interrupt accept always lands on the vector
  a_r6_irq_vector: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |=> pcValue == PC_W'(IRQ_VEC));

  // R8: fetch address stays inside implemented memory
  a_r8_in_range: assert property (@(posedge clk) disable iff (!rstN)
    32'(fetchAddr) < IMPL_WORDS);

  // R10: idle cycle holds the counter
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    noStrobe |=> $stable(pcValue));
endmodule

bind prog_seq_unit pcs_checker #(
  .PC_W      (PC_W),
  .IMPL_WORDS(IMPL_WORDS),
  .RESET_VEC (RESET_VEC),
  .IRQ_VEC   (IRQ_VEC)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .irqTake  (irqTake),
  .incEn    (incEn),
  .jumpEn   (jumpEn),
  .callEn   (callEn),
  .retEn    (retEn),
  .retfieEn (retfieEn),
  .retlwEn  (retlwEn),
  .jumpAddr (jumpAddr),
  .fetchAddr(fetchAddr),
  .pcValue  (pcValue)
);

// File: tb/prog_seq_unit_bench.sv
module prog_seq_unit_bench;
  localparam int W = 13;
  localparam logic [W-1:0] MASK = 13'h03FF;

  // op codes used by the bench only
  localparam logic [3:0] OP_NONE = 4'd0, OP_INC = 4'd1, OP_JMP = 4'd2,
    OP_CALL = 4'd3, OP_RET = 4'd4, OP_RETFIE = 4'd5, OP_RETLW = 4'd6,
    OP_IRQ = 4'd7;

  // {op, target, expected counter}
  localparam int NVEC = 16;
  localparam logic [29:0] VEC [NVEC] = '{
    {OP_INC,    13'h0000, 13'h0001},
    {OP_INC,    13'h0000, 13'h0002},
    {OP_JMP,    13'h0100, 13'h0100},
    {OP_CALL,   13'h0200, 13'h0200},
    {OP_INC,    13'h0000, 13'h0201},
    {OP_CALL,   13'h07FE, 13'h07FE},
    {OP_IRQ,    13'h0000, 13'h0004},
    {OP_INC,    13'h0000, 13'h0005},
    {OP_RETFIE, 13'h0000, 13'h07FE},
    {OP_INC,    13'h0000, 13'h07FF},
    {OP_INC,    13'h0000, 13'h0800},
    {OP_RETLW,  13'h0000, 13'h0202},
    {OP_RET,    13'h0000, 13'h0101},
    {OP_NONE,   13'h0000, 13'h0101},
    {OP_JMP,    13'h1FFF, 13'h1FFF},
    {OP_INC,    13'h0000, 13'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqTake = 1'b0, incEn = 1'b0, jumpEn = 1'b0, callEn = 1'b0;
  logic retEn = 1'b0, retfieEn = 1'b0, retlwEn = 1'b0;
  logic [W-1:0] jumpAddr = '0;
  logic [W-1:0] fetchAddr, pcValue;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  prog_seq_unit u_prog_seq_unit (
    .clk(clk), .rstN(rstN), .irqTake(irqTake), .incEn(incEn),
    .jumpEn(jumpEn), .callEn(callEn), .retEn(retEn), .retfieEn(retfieEn),
    .retlwEn(retlwEn), .jumpAddr(jumpAddr), .fetchAddr(fetchAddr),
    .pcValue(pcValue)
  );

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      OP_INC:    return "R2";
      OP_JMP:    return "R3";
      OP_CALL:   return "R4";
      OP_RET:    return "R5";
      OP_RETLW:  return "R5";
      OP_RETFIE: return "R6";
      OP_IRQ:    return "R6";
      default:   return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearStrobes();
    irqTake = 0; incEn = 0; jumpEn = 0; callEn = 0;
    retEn = 0; retfieEn = 0; retlwEn = 0; jumpAddr = '0;
  endtask

  // called at a negative edge; returns at the negative edge after the update
  task automatic step(input logic [3:0] op, input logic [W-1:0] addr);
    clearStrobes();
    jumpAddr = addr;
    case (op)
      OP_INC:    incEn = 1;
      OP_JMP:    jumpEn = 1;
      OP_CALL:   callEn = 1;
      OP_RET:    retEn = 1;
      OP_RETFIE: retfieEn = 1;
      OP_RETLW:  retlwEn = 1;
      OP_IRQ:    irqTake = 1;
      default:   ;
    endcase
    @(posedge clk);
    @(negedge clk);
    clearStrobes();
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin : main
    doReset();
    // R1: reset state
    check("R1", pcValue, 13'h0000);
    check("R1", fetchAddr, 13'h0000);

    // table walk: counter (per-op tag) and fetch alias (R8)
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][29:26], VEC[i][25:13]);
      check(tagOf(VEC[i][29:26]), pcValue, VEC[i][12:0]);
      check("R8", fetchAddr, VEC[i][12:0] & MASK);
    end

    // R1: pop straight after reset returns a cleared entry
    doReset();
    step(OP_JMP, 13'h0333);
    step(OP_RET, 13'h0000);
    check("R9", pcValue, 13'h0000);

    // R7: interrupt beats call/jump/advance; only one push happens
    doReset();
    step(OP_JMP, 13'h0040);
    step(OP_CALL, 13'h0500);          // pushes 0041
    clearStrobes();
    irqTake = 1; callEn = 1; incEn = 1; jumpEn = 1; jumpAddr = 13'h0AAA;
    @(posedge clk); @(negedge clk); clearStrobes();
    check("R7", pcValue, 13'h0004);
    step(OP_RETFIE, 13'h0000);
    check("R7", pcValue, 13'h0500);
    step(OP_RET, 13'h0000);
    check("R7", pcValue, 13'h0041);

    // R11: call beats jump and return; jump beats return; return beats advance
    doReset();
    clearStrobes();
    callEn = 1; jumpEn = 1; retEn = 1; incEn = 1; jumpAddr = 13'h0123;
    @(posedge clk); @(negedge clk); clearStrobes();
    check("R11", pcValue, 13'h0123);
    clearStrobes();
    jumpEn = 1; retlwEn = 1; incEn = 1; jumpAddr = 13'h0456;
    @(posedge clk); @(negedge clk); clearStrobes();
    check("R11", pcValue, 13'h0456);
    clearStrobes();
    retEn = 1; incEn = 1;
    @(posedge clk); @(negedge clk); clearStrobes();
    check("R11", pcValue, 13'h0001);

    // R7: reset holds the counter even with an interrupt raised
    @(negedge clk);
    rstN = 0; irqTake = 1;
    @(negedge clk);
    check("R7", pcValue, 13'h0000);
    rstN = 1; irqTake = 0;
    check("R1", pcValue, 13'h0000);

    // R9: nine nested calls wrap the stack
    doReset();
    for (int k = 1; k <= 9; k++) step(OP_CALL, W'(16 * k));
    for (int k = 9; k >= 2; k--) begin
      step(OP_RET, 13'h0000);
      check("R9", pcValue, W'(16 * (k - 1) + 1));
    end
    step(OP_RET, 13'h0000);
    check("R9", pcValue, 13'h0081);

    // R8: alias above implemented size
    step(OP_JMP, 13'h1C05);
    check("R8", fetchAddr, 13'h0005);
    check("R10", pcValue, 13'h1C05);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule